// File: doc/BRIEF.md
# Parity Small-Write Sequencer

This block performs a small write into one data block of a striped array that keeps a single dedicated parity disk. A requester names a stripe and a data disk, and it holds the replacement block in its own storage. The sequencer reads those words one at a time through an index output. It never reads the whole stripe. It makes four disk accesses in a fixed order:

1. Fetch the old data block.
2. Fetch the old parity block.
3. Store the new data block.
4. Store the new parity block.

Each new parity word is the XOR of the old parity word, the old data word and the new data word.

Every disk access goes through one shared port. A command is a valid/ready handshake that carries a write flag, a disk index and a stripe number. A read command is a single beat. The disk answers it with one response beat per word. A write access sends one handshake beat per word, and the disk answers with a single acknowledge beat. When the operation ends, the block raises a one-cycle `done` pulse. If the disk answers any access with an error, the operation stops at once, and `err` pulses together with a code that names the step that failed.

Top module: `parity_rmw_seq`

## Requirements
- R1: After reset the block is idle, with `req_ready` high, `dreq_valid` low, and `done` and `err` low. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the operation ends, so a request raised while busy has no effect.
- R2: The accesses of an operation occur in this order, all on the requested stripe:
  - a read of the requested disk;
  - a read of disk `PAR_DISK`;
  - a write of the requested disk;
  - a write of disk `PAR_DISK`.
- R3: A read command is exactly one accepted beat with `dreq_write`=0. A write access is exactly `BW` accepted beats with `dreq_write`=1, carrying words 0 to `BW`-1 in order. The disk and stripe fields are the same on every beat of one access.
- R4: Word i of the data write equals `nd_word` when `nd_idx` equals i.
- R5: Word i of the parity write equals old parity word i XOR old data word i XOR new data word i.
- R6: The first beat of the parity write is not offered before the data write's acknowledge has been received without error.
- R7: A response beat with `drsp_err`=1 ends the operation. `err` pulses for one cycle and `err_step` shows the failed access: 0 for the data read, 1 for the parity read, 2 for the data write, 3 for the parity write. No further command is offered after the failure, so a failure during either read leaves both disks unchanged.
- R8: `done` pulses for one cycle, in the cycle after the parity-write acknowledge is received without error. `done` and `err` are never high together.
- R9: While `dreq_valid` is high and `dreq_ready` is low, `dreq_valid` and every command field hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | High when idle and able to take a request |
| req_stripe | input | STRIPE_W | Stripe of the request |
| req_disk | input | DISK_W | Data disk to be updated |
| nd_idx | output | CNT_W | Index of the new data word being read |
| nd_word | input | DW | New data word at `nd_idx`, held by the requester |
| dreq_valid | output | 1 | Disk command or write beat valid |
| dreq_ready | input | 1 | Disk accepts the beat |
| dreq_write | output | 1 | 1 for a write beat, 0 for a read command |
| dreq_disk | output | DISK_W | Target disk |
| dreq_stripe | output | STRIPE_W | Target stripe |
| dreq_wdata | output | DW | Write data word |
| drsp_valid | input | 1 | Disk response beat |
| drsp_err | input | 1 | Response reports an error |
| drsp_data | input | DW | Read data word |
| done | output | 1 | Operation completed pulse |
| err | output | 1 | Operation aborted pulse |
| err_step | output | 2 | Failed step code, valid with `err` |

## Verification
The bench builds the block with 16-bit words, four words per block, four disks with parity on disk 3, and sixteen stripes. Because blocks are this short, every word-counter wrap and every step boundary comes up many times within a few thousand cycles. With only sixteen stripes, random requests often return to a stripe that has already been rewritten, so each update depends on the result of an earlier one. Random ready and response gaps stretch each handshake to different lengths. Errors are injected at each of the four steps, both on directed runs and on random ones.

// File: rtl/parity_rmw_seq.sv
module parity_rmw_seq #(
  parameter int DW       = 16,
  parameter int BW       = 4,
  parameter int DISK_W   = 2,
  parameter int STRIPE_W = 4,
  parameter int PAR_DISK = 3,
  localparam int CNT_W   = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [STRIPE_W-1:0] req_stripe,
  input  logic [DISK_W-1:0]   req_disk,
  output logic [CNT_W-1:0]    nd_idx,
  input  logic [DW-1:0]       nd_word,
  output logic                dreq_valid,
  input  logic                dreq_ready,
  output logic                dreq_write,
  output logic [DISK_W-1:0]   dreq_disk,
  output logic [STRIPE_W-1:0] dreq_stripe,
  output logic [DW-1:0]       dreq_wdata,
  input  logic                drsp_valid,
  input  logic                drsp_err,
  input  logic [DW-1:0]       drsp_data,
  output logic                done,
  output logic                err,
  output logic [1:0]          err_step
);

  typedef enum logic [3:0] {
    S_IDLE, S_RDC, S_RDD, S_RPC, S_RPD, S_WDD, S_WDA, S_WPD, S_WPA
  } st_e;

  localparam logic [CNT_W-1:0]  LAST = CNT_W'(BW - 1);
  localparam logic [DISK_W-1:0] PDSK = DISK_W'(PAR_DISK);

  st_e                 st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [STRIPE_W-1:0] stripe_q;
  logic [DISK_W-1:0]   disk_q;
  logic                done_q, err_q;
  logic [1:0]          step_q;
  logic [DW-1:0]       blk_q [BW];

  wire cnt_last = (cnt_q == LAST);
  wire [CNT_W-1:0] cnt_nx = cnt_last ? '0 : cnt_q + 1'b1;
  wire on_par = (st_q == S_RPC) || (st_q == S_WPD);
  wire rsp_ok = drsp_valid && !drsp_err;

  assign req_ready   = (st_q == S_IDLE);
  assign dreq_valid  = (st_q == S_RDC) || (st_q == S_RPC) || (st_q == S_WDD) || (st_q == S_WPD);
  assign dreq_write  = (st_q == S_WDD) || (st_q == S_WPD);
  assign dreq_disk   = on_par ? PDSK : disk_q;
  assign dreq_stripe = stripe_q;
  assign dreq_wdata  = (st_q == S_WDD) ? nd_word : (st_q == S_WPD) ? blk_q[cnt_q] : '0;
  assign nd_idx      = cnt_q;
  assign done        = done_q;
  assign err         = err_q;
  assign err_step    = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      stripe_q <= '0;
      disk_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      step_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          stripe_q <= req_stripe;
          disk_q   <= req_disk;
          cnt_q    <= '0;
          st_q     <= S_RDC;
        end
        S_RDC: if (dreq_ready) st_q <= S_RDD;
        S_RDD: if (drsp_valid) begin
          if (drsp_err) begin
            err_q <= 1'b1; step_q <= 2'd0; cnt_q <= '0; st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_nx;
            if (cnt_last) st_q <= S_RPC;
          end
        end
        S_RPC: if (dreq_ready) st_q <= S_RPD;
        S_RPD: if (drsp_valid) begin
          if (drsp_err) begin
            err_q <= 1'b1; step_q <= 2'd1; cnt_q <= '0; st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_nx;
            if (cnt_last) st_q <= S_WDD;
          end
        end
        S_WDD: if (dreq_ready) begin
          cnt_q <= cnt_nx;
          if (cnt_last) st_q <= S_WDA;
        end
        S_WDA: if (drsp_valid) begin
          if (drsp_err) begin
            err_q <= 1'b1; step_q <= 2'd2; st_q <= S_IDLE;
          end else st_q <= S_WPD;
        end
        S_WPD: if (dreq_ready) begin
          cnt_q <= cnt_nx;
          if (cnt_last) st_q <= S_WPA;
        end
        S_WPA: if (drsp_valid) begin
          if (drsp_err) begin
            err_q <= 1'b1; step_q <= 2'd3;
          end else done_q <= 1'b1;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_RDD && rsp_ok) blk_q[cnt_q] <= drsp_data;
    else if (st_q == S_RPD && rsp_ok) blk_q[cnt_q] <= drsp_data ^ blk_q[cnt_q] ^ nd_word;
  end

  AST_TAKE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_write) && $stable(dreq_disk)
      && $stable(dreq_stripe)); // R9
  AST_PAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq_valid && dreq_write && dreq_disk == PDSK) |-> $past(drsp_valid && !drsp_err)); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> req_ready && !dreq_valid); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err); // R8
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(drsp_valid && !drsp_err)); // R8

endmodule

// File: tb/tb_parity_rmw_seq.sv
module tb_parity_rmw_seq;
  localparam int DW = 16, BW = 4, DISK_W = 2, STRIPE_W = 4, PAR = 3, NS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [STRIPE_W-1:0] req_stripe = '0;
  logic [DISK_W-1:0] req_disk = '0;
  logic [1:0] nd_idx;
  logic [DW-1:0] nd_word;
  logic dreq_valid, dreq_ready = 1'b0, dreq_write;
  logic [DISK_W-1:0] dreq_disk;
  logic [STRIPE_W-1:0] dreq_stripe;
  logic [DW-1:0] dreq_wdata;
  logic drsp_valid = 1'b0, drsp_err = 1'b0;
  logic [DW-1:0] drsp_data = '0;
  logic done, err;
  logic [1:0] err_step;

  logic [DW-1:0] mem [4][NS][BW];
  logic [DW-1:0] nd_mem [BW];
  assign nd_word = nd_mem[nd_idx];

  parity_rmw_seq #(.DW(DW), .BW(BW), .DISK_W(DISK_W), .STRIPE_W(STRIPE_W), .PAR_DISK(PAR)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_stripe(req_stripe), .req_disk(req_disk), .nd_idx(nd_idx), .nd_word(nd_word),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_write(dreq_write),
    .dreq_disk(dreq_disk), .dreq_stripe(dreq_stripe), .dreq_wdata(dreq_wdata),
    .drsp_valid(drsp_valid), .drsp_err(drsp_err), .drsp_data(drsp_data),
    .done(done), .err(err), .err_step(err_step));

  int n_chk = 0, n_bad = 0;
  int n_acc = 0, inj = -1;
  logic acc_w [8];
  int acc_d [8], acc_s [8];
  int rd_left = 0, rd_i = 0, rd_d = 0, rd_s = 0, wi = 0, w_d = 0, w_s = 0;
  logic rd_err = 1'b0, ack_pend = 1'b0, ack_err = 1'b0;
  logic [DW-1:0] wbuf [BW];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [DW-1:0] exp_par(input logic [DW-1:0] op, input logic [DW-1:0] od,
                                            input logic [DW-1:0] nd);
    return op ^ od ^ nd;
  endfunction

  function automatic logic [DW-1:0] stripe_xor(input int s, input int w);
    return mem[0][s][w] ^ mem[1][s][w] ^ mem[2][s][w];
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  // disk model: drives at negedge, DUT samples at posedge
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      drsp_valid = 1'b0;
      drsp_err = 1'b0;
      if (rd_left > 0 && ($urandom % 4) != 0) begin
        drsp_valid = 1'b1;
        if (rd_err) begin
          drsp_err = 1'b1; drsp_data = DW'($urandom); rd_left = 0;
        end else begin
          drsp_data = mem[rd_d][rd_s][rd_i]; rd_i++; rd_left--;
        end
      end else if (ack_pend && ($urandom % 3) != 0) begin
        drsp_valid = 1'b1; drsp_err = ack_err; ack_pend = 1'b0;
      end
      dreq_ready = ($urandom % 4) != 0;
      if (dreq_valid && dreq_ready) begin
        if (rd_left > 0 || ack_pend)
          check(1'b0, "R3 beat while response pending", n_acc, -1);
        if (!dreq_write) begin
          if (n_acc < 8) begin
            acc_w[n_acc] = 1'b0; acc_d[n_acc] = int'(dreq_disk); acc_s[n_acc] = int'(dreq_stripe);
          end
          rd_err = (n_acc == inj);
          n_acc++;
          rd_left = BW; rd_i = 0; rd_d = int'(dreq_disk); rd_s = int'(dreq_stripe);
        end else begin
          if (wi == 0) begin
            w_d = int'(dreq_disk); w_s = int'(dreq_stripe);
          end else
            check(w_d == int'(dreq_disk) && w_s == int'(dreq_stripe), "R3 fields held in write",
                  int'(dreq_disk), w_d);
          wbuf[wi] = dreq_wdata;
          wi++;
          if (wi == BW) begin
            if (n_acc < 8) begin
              acc_w[n_acc] = 1'b1; acc_d[n_acc] = w_d; acc_s[n_acc] = w_s;
            end
            ack_err = (n_acc == inj);
            n_acc++;
            if (!ack_err) for (int k = 0; k < BW; k++) mem[w_d][w_s][k] = wbuf[k];
            ack_pend = 1'b1; wi = 0;
          end
        end
      end
    end
  end

  task automatic run_op(input int s, input int d, input int e, input logic hold);
    logic [DW-1:0] od [BW];
    logic [DW-1:0] op [BW];
    int exp_n, t;
    for (int k = 0; k < BW; k++) begin
      nd_mem[k] = DW'($urandom);
      od[k] = mem[d][s][k];
      op[k] = mem[PAR][s][k];
    end
    inj = e; n_acc = 0;
    @(negedge clk);
    req_stripe = STRIPE_W'(s); req_disk = DISK_W'(d); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold) begin
      req_stripe = STRIPE_W'(s + 1); req_disk = DISK_W'(d + 1);
      check(!req_ready, "R1 busy after accept", int'(req_ready), 0);
    end else req_valid = 1'b0;
    t = 0;
    while (!(done || err) && t < 2000) begin
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    exp_n = (e < 0) ? 4 : e + 1;
    check(done == (e < 0), "R8 done on success", int'(done), int'(e < 0));
    check(err == (e >= 0), "R7 err on failure", int'(err), int'(e >= 0));
    if (e >= 0) check(err_step == 2'(e), "R7 err_step", int'(err_step), e);
    @(negedge clk);
    check(!done && !err, "R8 single-cycle pulse", int'(done || err), 0);
    repeat (3) @(negedge clk);
    check(n_acc == exp_n, "R7 access count", n_acc, exp_n);
    check(req_ready && !dreq_valid, "R1 idle after end", int'(dreq_valid), 0);
    for (int i = 0; i < exp_n && i < 8; i++) begin
      int ed;
      ed = (i == 1 || i == 3) ? PAR : d;
      check(acc_w[i] == (i >= 2), "R2 access kind", int'(acc_w[i]), int'(i >= 2));
      check(acc_d[i] == ed, "R2 access disk", acc_d[i], ed);
      check(acc_s[i] == s, "R2 access stripe", acc_s[i], s);
    end
    for (int k = 0; k < BW; k++) begin
      if (e < 0 || e == 3)
        check(mem[d][s][k] == nd_mem[k], "R4 new data written", int'(mem[d][s][k]), int'(nd_mem[k]));
      else
        check(mem[d][s][k] == od[k], "R7 data unchanged", int'(mem[d][s][k]), int'(od[k]));
      if (e < 0)
        check(mem[PAR][s][k] == exp_par(op[k], od[k], nd_mem[k]), "R5 new parity",
              int'(mem[PAR][s][k]), int'(exp_par(op[k], od[k], nd_mem[k])));
      else
        check(mem[PAR][s][k] == op[k], "R7 parity unchanged", int'(mem[PAR][s][k]), int'(op[k]));
      mem[PAR][s][k] = stripe_xor(s, k);
    end
    inj = -1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < BW; k++) begin
        for (int d = 0; d < PAR; d++) mem[d][s][k] = DW'($urandom);
        mem[PAR][s][k] = stripe_xor(s, k);
      end
    for (int k = 0; k < BW; k++) nd_mem[k] = '0;
    repeat (4) @(negedge clk);
    check(req_ready && !dreq_valid && !done && !err, "R1 reset state", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !dreq_valid && !done && !err, "R1 idle after reset", int'(dreq_valid), 0);
    run_op(2, 0, -1, 1'b0);
    run_op(2, 0, -1, 1'b0);
    run_op(5, 1, 0, 1'b0);
    run_op(5, 1, 1, 1'b0);
    run_op(6, 2, 2, 1'b0);
    run_op(7, 0, 3, 1'b0);
    run_op(9, 2, -1, 1'b1);
    run_op(15, 1, -1, 1'b1);
    for (int n = 0; n < 60; n++) begin
      int e;
      e = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
      run_op(int'($urandom % NS), int'($urandom % PAR), e, ($urandom % 4) == 0);
    end
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < BW; k++)
        check(mem[PAR][s][k] == stripe_xor(s, k), "R5 stripe parity consistent",
              int'(mem[PAR][s][k]), int'(stripe_xor(s, k)));
    finish_run();
  end
endmodule